// File: doc/BRIEF.md
# Field-Flag Video Timing Receiver

This block sits at the digital input of a video encoder. It runs in the input timing mode where the sender supplies a horizontal sync, an odd/even field flag and, if it chooses, a blanking strobe. These arrive next to a byte-serial 4:2:2 pixel stream that carries one byte every two clocks. The block follows both 625-line and 525-line interlaced rasters, selected by a standard input.

The block reads a field flag that changes while horizontal sync is low as the start of a field. A change to the odd value also starts a frame. The block keeps a line counter and a pixel counter. When the external blanking strobe is switched off, it blanks on its own the vertical-blanking lines of the chosen standard and everything outside the active window. Each captured byte that is not blanked is routed to a Cb, Y or Cr output with a strobe. A field flag change while sync is high is treated as a sync fault and latched.

All inputs pass through one register stage. Below, "edge k" is the clock edge at which `hsyncIn` is first sampled low after being high.

Top module: `vid_field_sync_rx`

## Requirements
- R1: The mode only runs while `modeSel` equals 3'b011, and `modeActive` shows this. With any other code, `lineNum` and `pixNum` hold, no field, frame or sample strobe is produced, and field flag changes neither update `fieldOut` nor set `syncErr`.
- R2: After edge k+1, `lineNum` shows the previous value plus one, wrapping from 625 (625-line) or 525 (525-line) to 1. `pixNum` shows n after edges k+1+2n and k+2+2n, counting from 0.
- R3: A change of `fieldIn` that is sampled at an edge while the sampled `hsyncIn` is low gives a one-cycle `fieldStart` after the next edge. At that same edge `fieldOut` takes the new level (0 = odd, 1 = even), and `lineNum` is loaded with 1 for odd or with 313 (625-line) / 263 (525-line) for even.
- R4: `frameStart` pulses together with `fieldStart` only when the new field is odd.
- R5: A change of `fieldIn` that is sampled while `hsyncIn` is high leaves `fieldOut` unchanged and gives no `fieldStart`. It sets `syncErr` one edge later, and `syncErr` stays set until reset.
- R6: Pixel byte n must be held on `pixByte` for the edges k+2+2n and k+3+2n. The block takes it from the register filled at the first of these edges.
- R7: The vertical-blanking lines are 1–22, 311–335 and 623–625 in 625-line mode, and 1–21, 261–283 and 523–525 in 525-line mode. Lines 23 and 336 (625-line) are display lines.
- R8: With `blankEn` = 0, `blankOut` is 1 on vertical-blanking lines and whenever `pixNum` lies outside [hOff, hOff+ACT_BYTES). hOff defaults to 132 (625-line) or 122 (525-line).
- R9: With `blankEn` = 1, `blankOut` follows `blankIn` (1 = blank) as registered with the byte currently addressed.
- R10: Byte n that is not blanked comes out after edge k+3+2n. The lanes rotate Cb, Y, Cr, Y and restart at Cb when `pixNum` equals hOff. A Y byte goes to `yOut` with a `yValid` pulse. A Cb byte goes to `cbOut`. A Cr byte goes to `crOut` with a `chromaValid` pulse. A blanked byte produces no strobe.
- R11: While reset is held and just after it, `lineNum` = 1, `pixNum` = 0, `fieldOut` = 0, `syncErr` = 0, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, twice the byte rate |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 3 | Timing mode code; 3'b011 runs this mode |
| std625 | input | 1 | 1 = 625-line, 0 = 525-line |
| blankEn | input | 1 | 1 = use external blanking strobe |
| hsyncIn | input | 1 | Horizontal sync, active low |
| fieldIn | input | 1 | Field flag, 0 = odd, 1 = even |
| blankIn | input | 1 | External blanking strobe, 1 = blank |
| pixByte | input | DATA_W | Multiplexed Cb/Y/Cr byte stream |
| modeActive | output | 1 | This timing mode is selected |
| lineNum | output | LINE_W | Current line number, from 1 |
| pixNum | output | PIX_W | Half-rate count since sync fall |
| fieldOut | output | 1 | Current field |
| fieldStart | output | 1 | One-cycle pulse at each field start |
| frameStart | output | 1 | One-cycle pulse at each odd field start |
| syncErr | output | 1 | Sticky flag: field flag changed with sync high |
| blankOut | output | 1 | Blanking decision for the current byte |
| cbOut | output | DATA_W | Last Cb sample |
| yOut | output | DATA_W | Last Y sample |
| crOut | output | DATA_W | Last Cr sample |
| yValid | output | 1 | Pulse: new Y sample |
| chromaValid | output | 1 | Pulse: new Cr sample, Cb/Cr pair complete |

## Verification
The bench generates every line with sync falling at a known edge k. It then checks each result in the cycle it is due. The line count appears one edge after the sync sample. A field event's strobe, line load and field value appear two edges after the sync sample, and the sync fault one edge after the offending sample. The pixel count and blanking are checked on even offsets 2+2n, and the sample strobes and values on odd offsets 3+2n. Every sample is taken 1 ns after a rising edge, before the next inputs are driven. The expected lane follows its own copy of the rotation, which restarts at hOff and advances only on samples that are not blanked.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  localparam int unsigned LINES_625 = 625;
  localparam int unsigned LINES_525 = 525;
  localparam int unsigned EVEN_FIRST_625 = 313;
  localparam int unsigned EVEN_FIRST_525 = 263;
  localparam logic [2:0] MODE_CODE = 3'b011;

  typedef enum logic [1:0] {
    LANE_CB = 2'd0,
    LANE_Y0 = 2'd1,
    LANE_CR = 2'd2,
    LANE_Y1 = 2'd3
  } lane_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;     // capture the registered byte into its lane
    logic laneRst;  // first byte of the active window: lane back to Cb
  } strb_t;

  // Vertical-blanking line test for both rasters
  function automatic logic isVBlank(input logic is625, input logic [15:0] ln);
    if (is625)
      return (ln <= 16'd22) || ((ln >= 16'd311) && (ln <= 16'd335)) || (ln >= 16'd623);
    else
      return (ln <= 16'd21) || ((ln >= 16'd261) && (ln <= 16'd283)) || (ln >= 16'd523);
  endfunction

endpackage

// File: rtl/vfs_ctrl.sv
module vfs_ctrl
  import vfs_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int PIX_W     = 12,
  parameter int H_OFF_625 = 132,
  parameter int H_OFF_525 = 122,
  parameter int ACT_BYTES = 1440
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              std625,
  input  logic              blankEn,
  input  logic              hsyncIn,
  input  logic              fieldIn,
  input  logic              blankIn,
  output strb_t             strb,
  output logic              modeActive,
  output logic [LINE_W-1:0] lineNum,
  output logic [PIX_W-1:0]  pixNum,
  output logic              fieldOut,
  output logic              fieldStart,
  output logic              frameStart,
  output logic              syncErr,
  output logic              blankOut
);

  localparam int PW1 = PIX_W + 1;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic hsR, hsD, fldR, fldD, blkR;
  logic phase;
  logic modeOk, hsFall, fldChg, fldEvt, fldBad;
  logic [LINE_W-1:0] lineTop, evenFirst;
  logic [PIX_W-1:0]  hOff;
  logic [PW1-1:0]    winEnd;
  logic inWin, intBlank;

  // Input capture stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsR  <= 1'b1;
      hsD  <= 1'b1;
      fldR <= 1'b0;
      fldD <= 1'b0;
      blkR <= 1'b1;
    end else begin
      hsR  <= hsyncIn;
      hsD  <= hsR;
      fldR <= fieldIn;
      fldD <= fldR;
      blkR <= blankIn;
    end
  end

  assign modeOk     = (modeSel == MODE_CODE);
  assign modeActive = modeOk;
  assign hsFall     = hsD & ~hsR;
  assign fldChg     = fldR ^ fldD;
  assign fldEvt     = modeOk & fldChg & ~hsR;
  assign fldBad     = modeOk & fldChg & hsR;

  assign lineTop   = std625 ? LINE_W'(LINES_625) : LINE_W'(LINES_525);
  assign evenFirst = std625 ? LINE_W'(EVEN_FIRST_625) : LINE_W'(EVEN_FIRST_525);
  assign hOff      = std625 ? PIX_W'(H_OFF_625) : PIX_W'(H_OFF_525);
  assign winEnd    = PW1'(hOff) + PW1'(ACT_BYTES);

  // Line counter: field load wins over sync advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineNum <= LINE_W'(1);
    end else if (fldEvt) begin
      lineNum <= fldR ? evenFirst : LINE_W'(1);
    end else if (modeOk && hsFall) begin
      lineNum <= (lineNum == lineTop) ? LINE_W'(1) : lineNum + 1'b1;
    end
  end

  // Half-rate pixel counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixNum <= '0;
      phase  <= 1'b0;
    end else if (modeOk) begin
      if (hsFall) begin
        pixNum <= '0;
        phase  <= 1'b0;
      end else begin
        phase <= ~phase;
        if (phase && (pixNum != PIX_MAX)) pixNum <= pixNum + 1'b1;
      end
    end
  end

  // Field tracking and sync fault
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldOut   <= 1'b0;
      fieldStart <= 1'b0;
      frameStart <= 1'b0;
      syncErr    <= 1'b0;
    end else begin
      fieldStart <= fldEvt;
      frameStart <= fldEvt & ~fldR;
      if (fldEvt) fieldOut <= fldR;
      if (fldBad) syncErr <= 1'b1;
    end
  end

  // Blanking decision
  assign inWin    = (pixNum >= hOff) && (PW1'(pixNum) < winEnd);
  assign intBlank = isVBlank(std625, 16'(lineNum)) | ~inWin;
  assign blankOut = blankEn ? blkR : intBlank;

  assign strb.take    = modeOk & phase & ~blankOut;
  assign strb.laneRst = modeOk & phase & (pixNum == hOff);

endmodule

// File: rtl/vfs_dpath.sv
module vfs_dpath
  import vfs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pixByte,
  input  strb_t             strb,
  output logic [DATA_W-1:0] cbOut,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] crOut,
  output logic              yValid,
  output logic              chromaValid
);

  logic [DATA_W-1:0] byteR;
  lane_e lane, laneCur;

  assign laneCur = strb.laneRst ? LANE_CB : lane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteR <= '0;
    else       byteR <= pixByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lane        <= LANE_CB;
      cbOut       <= '0;
      yOut        <= '0;
      crOut       <= '0;
      yValid      <= 1'b0;
      chromaValid <= 1'b0;
    end else begin
      yValid      <= strb.take & ((laneCur == LANE_Y0) | (laneCur == LANE_Y1));
      chromaValid <= strb.take & (laneCur == LANE_CR);
      if (strb.take) begin
        unique case (laneCur)
          LANE_CB:          cbOut <= byteR;
          LANE_CR:          crOut <= byteR;
          LANE_Y0, LANE_Y1: yOut  <= byteR;
        endcase
        lane <= lane_e'(laneCur + 2'd1);
      end else if (strb.laneRst) begin
        lane <= LANE_CB;
      end
    end
  end

endmodule

// File: rtl/vid_field_sync_rx.sv
module vid_field_sync_rx
  import vfs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 10,
  parameter int PIX_W     = 12,
  parameter int H_OFF_625 = 132,
  parameter int H_OFF_525 = 122,
  parameter int ACT_BYTES = 1440
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              std625,
  input  logic              blankEn,
  input  logic              hsyncIn,
  input  logic              fieldIn,
  input  logic              blankIn,
  input  logic [DATA_W-1:0] pixByte,
  output logic              modeActive,
  output logic [LINE_W-1:0] lineNum,
  output logic [PIX_W-1:0]  pixNum,
  output logic              fieldOut,
  output logic              fieldStart,
  output logic              frameStart,
  output logic              syncErr,
  output logic              blankOut,
  output logic [DATA_W-1:0] cbOut,
  output logic [DATA_W-1:0] yOut,
  output logic [DATA_W-1:0] crOut,
  output logic              yValid,
  output logic              chromaValid
);

  strb_t strb;

  vfs_ctrl #(
    .LINE_W   (LINE_W),
    .PIX_W    (PIX_W),
    .H_OFF_625(H_OFF_625),
    .H_OFF_525(H_OFF_525),
    .ACT_BYTES(ACT_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .std625    (std625),
    .blankEn   (blankEn),
    .hsyncIn   (hsyncIn),
    .fieldIn   (fieldIn),
    .blankIn   (blankIn),
    .strb      (strb),
    .modeActive(modeActive),
    .lineNum   (lineNum),
    .pixNum    (pixNum),
    .fieldOut  (fieldOut),
    .fieldStart(fieldStart),
    .frameStart(frameStart),
    .syncErr   (syncErr),
    .blankOut  (blankOut)
  );

  vfs_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .pixByte    (pixByte),
    .strb       (strb),
    .cbOut      (cbOut),
    .yOut       (yOut),
    .crOut      (crOut),
    .yValid     (yValid),
    .chromaValid(chromaValid)
  );

endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              std625,
  input logic              modeActive,
  input logic [LINE_W-1:0] lineNum,
  input logic              fieldOut,
  input logic              fieldStart,
  input logic              frameStart,
  input logic              syncErr,
  input logic              blankOut,
  input logic              yValid,
  input logic              chromaValid
);

  // R4
  a_r4_frame_with_field: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> fieldStart);

  // R4
  a_r4_frame_is_odd: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !fieldOut);

  // R3
  a_r3_field_loads_line: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |-> (fieldOut ? (lineNum == (std625 ? LINE_W'(313) : LINE_W'(263)))
                             : (lineNum == LINE_W'(1))));

  // R5
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    syncErr |=> syncErr);

  // R10
  a_r10_one_lane: assert property (@(posedge clk) disable iff (!rstN)
    !(yValid && chromaValid));

  // R10
  a_r10_no_blank_sample: assert property (@(posedge clk) disable iff (!rstN)
    (yValid || chromaValid) |-> !$past(blankOut));

  // R1
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !modeActive |=> !yValid && !chromaValid && !fieldStart);

  // R2
  a_r2_line_range: assert property (@(posedge clk) disable iff (!rstN)
    (lineNum >= LINE_W'(1)) && (lineNum <= LINE_W'(625)));

endmodule

bind vid_field_sync_rx vfs_checker #(.LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .std625     (std625),
  .modeActive (modeActive),
  .lineNum    (lineNum),
  .fieldOut   (fieldOut),
  .fieldStart (fieldStart),
  .frameStart (frameStart),
  .syncErr    (syncErr),
  .blankOut   (blankOut),
  .yValid     (yValid),
  .chromaValid(chromaValid)
);

// File: tb/test_vid_field_sync_rx.sv
`timescale 1ns/1ps
module test_vid_field_sync_rx;

  localparam int HO625 = 5;
  localparam int HO525 = 6;
  localparam int ACTB  = 8;
  localparam int LCYC  = 48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeSel = 3'b011;
  logic std625 = 1'b1;
  logic blankEn = 1'b0;
  logic hsyncIn = 1'b1;
  logic fieldIn = 1'b0;
  logic blankIn = 1'b1;
  logic [7:0] pixByte = 8'h00;
  logic modeActive, fieldOut, fieldStart, frameStart, syncErr, blankOut;
  logic yValid, chromaValid;
  logic [9:0] lineNum;
  logic [11:0] pixNum;
  logic [7:0] cbOut, yOut, crOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int expLine, laneM;
  bit expField, expErr, fldLevel;

  always #5 clk = ~clk;

  vid_field_sync_rx #(
    .H_OFF_625(HO625), .H_OFF_525(HO525), .ACT_BYTES(ACTB)
  ) i_vid_field_sync_rx (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .std625(std625),
    .blankEn(blankEn), .hsyncIn(hsyncIn), .fieldIn(fieldIn),
    .blankIn(blankIn), .pixByte(pixByte), .modeActive(modeActive),
    .lineNum(lineNum), .pixNum(pixNum), .fieldOut(fieldOut),
    .fieldStart(fieldStart), .frameStart(frameStart), .syncErr(syncErr),
    .blankOut(blankOut), .cbOut(cbOut), .yOut(yOut), .crOut(crOut),
    .yValid(yValid), .chromaValid(chromaValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (line %0d)", req, act, exp, expLine);
    end
  endtask

  function automatic bit vbExp(input bit s, input int l);
    if (s) return (l <= 22) || (l >= 311 && l <= 335) || (l >= 623);
    return (l <= 21) || (l >= 261 && l <= 283) || (l >= 523);
  endfunction

  function automatic int topF(input bit s);
    return s ? 625 : 525;
  endfunction

  function automatic int hOffF(input bit s);
    return s ? HO625 : HO525;
  endfunction

  task automatic doReset();
    fieldIn = 1'b0;
    hsyncIn = 1'b1;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11 lineNum", 32'(lineNum), 32'd1);
    chk("R11 pixNum", 32'(pixNum), 32'd0);
    chk("R11 fieldOut", 32'(fieldOut), 32'd0);
    chk("R11 syncErr", 32'(syncErr), 32'd0);
    chk("R11 strobes", {28'd0, fieldStart, frameStart, yValid, chromaValid}, 32'd0);
    rstN = 1'b1;
    expLine = 1; expField = 1'b0; expErr = 1'b0; fldLevel = 1'b0; laneM = 0;
  endtask

  // One line: sync falls at edge k (j = 0); checks sampled after each edge k+j
  task automatic runLine(input bit legitTog, input bit badTog);
    logic [7:0] bytes [0:23];
    bit blk [0:23];
    bit on;
    int ho, n, lane;
    bit expBlank, expTake, evt;
    on = (modeSel == 3'b011);
    ho = hOffF(std625);
    evt = 1'b0;
    for (int i = 0; i < 24; i++) begin
      bytes[i] = 8'($urandom);
      blk[i] = (i < ho || i >= ho + ACTB) ? 1'b1 : (($urandom % 4) == 0);
    end
    for (int j = 0; j < LCYC; j++) begin
      hsyncIn = (j < 4) ? 1'b0 : 1'b1;
      if (j == 1 && legitTog) begin fieldIn = ~fieldIn; fldLevel = ~fldLevel; evt = on; end
      if (j == 10 && badTog) begin fieldIn = ~fieldIn; fldLevel = ~fldLevel; if (on) expErr = 1'b1; end
      n = (j >= 2) ? (j - 2) / 2 : 0;
      pixByte = bytes[n];
      blankIn = blk[n];
      @(posedge clk);
      #1;
      if (!on) begin
        // R1: idle mode
        chk("R1 lineNum holds", 32'(lineNum), 32'(expLine));
        chk("R1 no strobes", {29'd0, fieldStart, yValid, chromaValid}, 32'd0);
        chk("R1 fieldOut holds", 32'(fieldOut), 32'(expField));
        chk("R1 syncErr", 32'(syncErr), 32'(expErr));
        continue;
      end
      if (j == 1) begin
        expLine = (expLine == topF(std625)) ? 1 : expLine + 1;
        chk("R2 line advance", 32'(lineNum), 32'(expLine));
      end
      if (j == 2 && evt) begin
        expField = fldLevel;
        expLine = fldLevel ? (std625 ? 313 : 263) : 1;
      end
      chk("R3 fieldStart", 32'(fieldStart), 32'(j == 2 && evt));
      chk("R4 frameStart", 32'(frameStart), 32'(j == 2 && evt && !expField));
      if (j == 3) begin
        chk("R3 line load", 32'(lineNum), 32'(expLine));
        chk("R3 fieldOut", 32'(fieldOut), 32'(expField));
        chk("R5 syncErr sticky", 32'(syncErr), 32'(expErr));
      end
      if (j == 11 && badTog) begin
        chk("R5 syncErr set", 32'(syncErr), 32'd1);
        chk("R5 fieldOut unchanged", 32'(fieldOut), 32'(expField));
      end
      if (j >= 2 && (j % 2) == 0) begin
        n = (j - 2) / 2;
        chk("R2 pixNum", 32'(pixNum), 32'(n));
        expBlank = blankEn ? blk[n] : (vbExp(std625, expLine) || n < ho || n >= ho + ACTB);
        chk(blankEn ? "R9 blankOut" : "R8 R7 blankOut", 32'(blankOut), 32'(expBlank));
      end
      if (j >= 3 && (j % 2) == 1) begin
        n = (j - 3) / 2;
        expBlank = blankEn ? blk[n] : (vbExp(std625, expLine) || n < ho || n >= ho + ACTB);
        if (n == ho) laneM = 0;
        expTake = !expBlank;
        if (expTake) begin
          lane = laneM;
          laneM = (laneM + 1) % 4;
          chk("R10 yValid", 32'(yValid), 32'(lane == 1 || lane == 3));
          chk("R10 chromaValid", 32'(chromaValid), 32'(lane == 2));
          if (lane == 0) chk("R6 R10 cbOut", 32'(cbOut), 32'(bytes[n]));
          if (lane == 2) chk("R6 R10 crOut", 32'(crOut), 32'(bytes[n]));
          if (lane == 1 || lane == 3) chk("R6 R10 yOut", 32'(yOut), 32'(bytes[n]));
        end else begin
          chk("R10 blanked no strobe", {30'd0, yValid, chromaValid}, 32'd0);
        end
      end else begin
        chk("R10 no strobe off-phase", {30'd0, yValid, chromaValid}, 32'd0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // 625-line raster, internal blanking
    std625 = 1'b1; blankEn = 1'b0; modeSel = 3'b011;
    doReset();
    chk("R11 blankOut line 1", 32'(blankOut), 32'd1);
    chk("R1 modeActive", 32'(modeActive), 32'd1);
    runLine(1'b1, 1'b0);                           // even field -> 313
    while (expLine != 625) runLine(1'b0, 1'b0);    // through 335/336 boundary
    runLine(1'b0, 1'b0);                           // wrap to 1
    chk("R2 wrap 625", 32'(lineNum), 32'd1);
    runLine(1'b1, 1'b0);                           // odd field, frame start
    while (expLine != 30) runLine(1'b0, 1'b0);     // through 22/23 boundary
    // R1: idle codes, then back on
    modeSel = 3'b101;
    chk("R1 modeActive off", 32'(modeActive), 32'd0);
    runLine(1'b1, 1'b0);
    runLine(1'b0, 1'b0);
    modeSel = 3'b011;
    runLine(1'b0, 1'b0);
    runLine(1'b1, 1'b0);
    // R9: external blanking
    blankEn = 1'b1;
    for (int i = 0; i < 6; i++) runLine(1'b0, 1'b0);
    blankEn = 1'b0;
    // R5: field change with sync high
    runLine(1'b0, 1'b1);
    runLine(1'b0, 1'b0);
    runLine(1'b1, 1'b0);
    // 525-line raster
    std625 = 1'b0;
    doReset();
    runLine(1'b1, 1'b0);                           // even -> 263
    while (expLine != 525) runLine(1'b0, 1'b0);
    runLine(1'b0, 1'b0);
    chk("R2 wrap 525", 32'(lineNum), 32'd1);
    runLine(1'b1, 1'b0);
    while (expLine != 25) runLine(1'b0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule